// File: doc/BRIEF.md
# Manchester frame ID decoder

This block takes a serial stream of recovered line bits, one bit per `in_valid_i` cycle. It pulls out identifiers that are sent between frame markers. A marker is the six-bit run 1,1,1,0,0,0. That run cannot occur inside valid Manchester data, so the decoder can lock onto it at any bit offset. After a marker, the bits are read in pairs, and each pair that changes level gives one data bit. The data bits shift into a 96-bit register built from three 32-bit words. The first pair whose two bits are equal ends the payload.

The identifier is accepted only when a fresh marker starts exactly at that equal pair. That closing marker also opens the next frame, so identifiers sent back to back are each reported. On acceptance, the block pulses `id_valid_o` for one cycle and updates the three ID words and the data-bit count. These outputs then hold until the next accepted frame. A first-only mode parks the decoder after its first accepted identifier, and it stays parked until it is re-armed.

The control FSM has five states:

- **HUNT**: slides the window one bit at a time and looks for a marker.
- **LEAD**: takes the first bit of a pair.
- **TRAIL**: takes the second bit of a pair.
- **CLOSE**: collects the last four bits of a candidate closing marker.
- **HALT**: parked in first-only mode.

It has these transitions:

| Transition | From | To | Taken when |
|---|---|---|---|
| *sync* | HUNT | LEAD | a marker is seen |
| *pair_ok* | TRAIL | LEAD | the two bits of the pair differ |
| *pair_eq* | TRAIL | CLOSE | the two bits of the pair are equal |
| *accept_run* | CLOSE | LEAD | a marker is seen, first-only is clear |
| *accept_stop* | CLOSE | HALT | a marker is seen, first-only is set |
| *reject* | CLOSE | HUNT | no marker is seen |
| *rearm* | HALT | HUNT | `rearm_i` is asserted |

LEAD always moves to TRAIL on the next valid bit.

Top module: `mfd_id_decoder`

## Requirements
- R1: After reset, `id_valid_o` is 0, the three ID words and `shift_cnt_o` are 0, and the decoder is searching for a marker.
- R2: Searching checks the six most recent valid bits against 1,1,1,0,0,0 (oldest first) on every valid bit. A mismatch moves the search by one bit position, so a marker preceded by extra 1s is still found.
- R3: After a marker, each pair 1,0 gives data bit 0 and each pair 0,1 gives data bit 1. Each data bit enters bit 0 of the low word. Bit 31 of the low word carries into bit 0 of the middle word, and bit 31 of the middle word carries into bit 0 of the high word. The first data bit ends up as the most significant bit received.
- R4: A pair whose two bits are equal ends the payload and adds no data bit.
- R5: A frame is reported only when the six bits starting at the equal pair form a marker. The report is a one-cycle `id_valid_o` pulse in the cycle after the last marker bit is accepted. The ID words and count change only together with that pulse and hold otherwise. A payload of zero pairs reports ID 0 with count 0.
- R6: When the bits after an equal pair do not form a marker, nothing is reported. The search resumes at the bit after the first bit of the equal pair, so a marker that overlaps the rejected bits is still found.
- R7: A closing marker also acts as the opening marker of the next frame, so back-to-back frames are each reported.
- R8: The ID register and count are cleared at each opening marker and after each close attempt. Each reported ID and count reflect that frame's data bits only.
- R9: `shift_cnt_o` reports the number of data bits in the frame, saturating at 255. A longer payload reports the last 96 data bits.
- R10: Cycles with `in_valid_i` low change no decoder state and no output.
- R11: With `first_only_i` high, after the first report the decoder ignores all input until `rearm_i` is pulsed. The rearm pulse returns it to searching with an empty bit history, and `rearm_i` has no effect in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | `in_bit_i` carries a stream bit this cycle |
| in_bit_i | input | 1 | Stream bit |
| first_only_i | input | 1 | Stop after the first reported ID |
| rearm_i | input | 1 | Leave the stopped state and resume searching |
| id_valid_o | output | 1 | One-cycle pulse for a newly reported ID |
| id_hi_o | output | 32 | ID bits 95..64 |
| id_mid_o | output | 32 | ID bits 63..32 |
| id_lo_o | output | 32 | ID bits 31..0 |
| shift_cnt_o | output | 8 | Data bits in the reported frame, saturating |

## Verification
The assertions rely on three properties of the inputs:

- All inputs are known, with no X values, whenever reset is released.
- `rearm_i` is pulsed only while the decoder is parked, with `in_valid_i` low.
- `first_only_i` stays steady for the whole of each frame.

The stimulus drives every input to a defined value from time zero. It changes the mode only during idle or flushing stretches, and it issues rearm pulses only after a first-only report, with no bit presented in that cycle. The frames themselves include corrupted pairs, payloads that run on past saturation, markers at odd offsets, and gaps in the valid strobe. All of these are legal input patterns, and the checks cover them.

// File: rtl/mfd_pkg.sv
package mfd_pkg;

    localparam int WORD_W   = 32;
    localparam int N_WORDS  = 3;
    localparam int ID_W     = WORD_W * N_WORDS;
    localparam int MARK_LEN = 6;
    localparam logic [MARK_LEN-1:0] MARK_PAT = 6'b111000;

    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_TRAIL = 3'd2,
        ST_CLOSE = 3'd3,
        ST_HALT  = 3'd4
    } dec_state_e;

endpackage

// File: rtl/mfd_window.sv
// Sliding history of the most recent stream bits; oldest bit at the MSB.
module mfd_window #(
    parameter int                 LEN = 6,
    parameter logic [LEN-1:0]     PAT = 6'b111000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic shift_i,
    input  logic bit_i,
    output logic match_o
);

    logic [LEN-1:0] win_q;
    logic [LEN-1:0] win_next;

    // Window as it will look once the present bit is taken in.
    assign win_next = {win_q[LEN-2:0], bit_i};
    assign match_o  = (win_next == PAT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            win_q <= '0;
        end else if (clr_i) begin
            win_q <= '0;
        end else if (shift_i) begin
            win_q <= win_next;
        end
    end

endmodule

// File: rtl/mfd_idshift.sv
// Multi-word ID shift register with a saturating data-bit counter.
module mfd_idshift #(
    parameter int WORD_W  = 32,
    parameter int N_WORDS = 3,
    parameter int CNT_W   = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       clr_i,
    input  logic                       shift_i,
    input  logic                       bit_i,
    output logic [WORD_W*N_WORDS-1:0]  id_o,
    output logic [CNT_W-1:0]           cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        logic [WORD_W-1:0] w_q;
        logic              carry;

        if (k == 0) begin : g_first
            assign carry = bit_i;
        end else begin : g_upper
            assign carry = g_word[k-1].w_q[WORD_W-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                w_q <= '0;
            end else if (clr_i) begin
                w_q <= '0;
            end else if (shift_i) begin
                w_q <= {w_q[WORD_W-2:0], carry};
            end
        end

        assign id_o[k*WORD_W +: WORD_W] = w_q;

        if (k > 0) begin : g_chk
            // R3: top bit of the word below lands in bit 0 of this word
            p_word_carry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (shift_i && !clr_i) |=> (w_q[0] == $past(g_word[k-1].w_q[WORD_W-1])));
        end
    end

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (shift_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R9: a saturated count never wraps
    p_cnt_sat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/mfd_ctrl.sv
// Frame sequencing FSM: hunt, pair decode, close check, parked.
module mfd_ctrl
    import mfd_pkg::*;
#(
    parameter int MARK_LEN = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic valid_i,
    input  logic bit_i,
    input  logic match_i,
    input  logic first_only_i,
    input  logic rearm_i,
    output logic win_shift_o,
    output logic win_clr_o,
    output logic id_clr_o,
    output logic id_shift_o,
    output logic report_o
);

    // After an equal pair, MARK_LEN-2 further bits complete the candidate.
    localparam int CLS_W = $clog2(MARK_LEN - 2);
    localparam logic [CLS_W-1:0] CLOSE_LAST = CLS_W'(MARK_LEN - 3);

    dec_state_e        state_q, state_d;
    logic              lead_q, lead_d;
    logic [CLS_W-1:0]  close_q, close_d;
    logic              close_done;

    assign close_done = (state_q == ST_CLOSE) && valid_i && (close_q == CLOSE_LAST);

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HUNT;
            lead_q  <= 1'b0;
            close_q <= '0;
        end else begin
            state_q <= state_d;
            lead_q  <= lead_d;
            close_q <= close_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        lead_d  = lead_q;
        close_d = close_q;
        unique case (state_q)
            ST_HUNT: begin
                if (valid_i && match_i) begin
                    state_d = ST_LEAD;                       // sync
                end
            end
            ST_LEAD: begin
                if (valid_i) begin
                    lead_d  = bit_i;
                    state_d = ST_TRAIL;
                end
            end
            ST_TRAIL: begin
                if (valid_i) begin
                    if (bit_i != lead_q) begin
                        state_d = ST_LEAD;                   // pair_ok
                    end else begin
                        state_d = ST_CLOSE;                  // pair_eq
                        close_d = '0;
                    end
                end
            end
            ST_CLOSE: begin
                if (valid_i) begin
                    if (close_q == CLOSE_LAST) begin
                        if (match_i) begin
                            state_d = first_only_i ? ST_HALT : ST_LEAD; // accept
                        end else begin
                            state_d = ST_HUNT;               // reject
                        end
                    end else begin
                        close_d = close_q + 1'b1;
                    end
                end
            end
            ST_HALT: begin
                if (rearm_i) begin
                    state_d = ST_HUNT;                       // rearm
                end
            end
            default: begin
                state_d = ST_HUNT;
            end
        endcase
    end

    // Outputs
    always_comb begin
        win_shift_o = valid_i && (state_q != ST_HALT);
        win_clr_o   = (state_q == ST_HALT) && rearm_i;
        id_clr_o    = ((state_q == ST_HUNT) && valid_i && match_i) || close_done;
        id_shift_o  = (state_q == ST_TRAIL) && valid_i && (bit_i != lead_q);
        report_o    = close_done && match_i;
    end

    // R10: no valid bit, no movement
    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!valid_i && state_q != ST_HALT) |=> $stable(state_q));

    // R11: parked until rearmed
    p_halt_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HALT && !rearm_i) |=> (state_q == ST_HALT));

    // R4: an equal pair always leads to the close check
    p_equal_pair_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TRAIL && valid_i && bit_i == lead_q) |=> (state_q == ST_CLOSE));

    // R7: an accepted closing marker opens the next payload
    p_chain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (report_o && !first_only_i) |=> (state_q == ST_LEAD));

endmodule

// File: rtl/mfd_id_decoder.sv
module mfd_id_decoder
    import mfd_pkg::*;
#(
    parameter int WORD_W = mfd_pkg::WORD_W,
    parameter int CNT_W  = $clog2(3 * WORD_W) + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic              in_bit_i,
    input  logic              first_only_i,
    input  logic              rearm_i,
    output logic              id_valid_o,
    output logic [WORD_W-1:0] id_hi_o,
    output logic [WORD_W-1:0] id_mid_o,
    output logic [WORD_W-1:0] id_lo_o,
    output logic [CNT_W-1:0]  shift_cnt_o
);

    localparam int NW   = 3;
    localparam int ID_B = WORD_W * NW;

    logic             win_shift, win_clr, match;
    logic             id_clr, id_shift, report;
    logic [ID_B-1:0]  id_live;
    logic [CNT_W-1:0] cnt_live;

    mfd_window #(
        .LEN (MARK_LEN),
        .PAT (MARK_PAT)
    ) u_window (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (win_clr),
        .shift_i (win_shift),
        .bit_i   (in_bit_i),
        .match_o (match)
    );

    mfd_ctrl #(
        .MARK_LEN (MARK_LEN)
    ) u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .valid_i      (in_valid_i),
        .bit_i        (in_bit_i),
        .match_i      (match),
        .first_only_i (first_only_i),
        .rearm_i      (rearm_i),
        .win_shift_o  (win_shift),
        .win_clr_o    (win_clr),
        .id_clr_o     (id_clr),
        .id_shift_o   (id_shift),
        .report_o     (report)
    );

    mfd_idshift #(
        .WORD_W  (WORD_W),
        .N_WORDS (NW),
        .CNT_W   (CNT_W)
    ) u_idshift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (id_clr),
        .shift_i (id_shift),
        .bit_i   (in_bit_i),
        .id_o    (id_live),
        .cnt_o   (cnt_live)
    );

    logic             rep_q;
    logic [ID_B-1:0]  rep_id_q;
    logic [CNT_W-1:0] rep_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rep_q     <= 1'b0;
            rep_id_q  <= '0;
            rep_cnt_q <= '0;
        end else begin
            rep_q <= report;
            if (report) begin
                rep_id_q  <= id_live;
                rep_cnt_q <= cnt_live;
            end
        end
    end

    assign id_valid_o  = rep_q;
    assign id_lo_o     = rep_id_q[WORD_W-1:0];
    assign id_mid_o    = rep_id_q[2*WORD_W-1:WORD_W];
    assign id_hi_o     = rep_id_q[3*WORD_W-1:2*WORD_W];
    assign shift_cnt_o = rep_cnt_q;

    // R5: a report is a single-cycle pulse
    p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        id_valid_o |=> !id_valid_o);

    // R5: reported values only move with the pulse
    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !id_valid_o |-> ($stable(id_lo_o) && $stable(id_mid_o) &&
                         $stable(id_hi_o) && $stable(shift_cnt_o)));

endmodule

// File: tb/mfd_id_decoder_tb.sv
module mfd_id_decoder_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        in_bit_i = 1'b0;
    logic        first_only_i = 1'b0;
    logic        rearm_i = 1'b0;
    logic        id_valid_o;
    logic [31:0] id_hi_o, id_mid_o, id_lo_o;
    logic [7:0]  shift_cnt_o;

    always #2 clk_i = ~clk_i;   // 250 MHz

    mfd_id_decoder dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .in_valid_i   (in_valid_i),
        .in_bit_i     (in_bit_i),
        .first_only_i (first_only_i),
        .rearm_i      (rearm_i),
        .id_valid_o   (id_valid_o),
        .id_hi_o      (id_hi_o),
        .id_mid_o     (id_mid_o),
        .id_lo_o      (id_lo_o),
        .shift_cnt_o  (shift_cnt_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    bit gap_en = 1'b0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          hist[$];
    int          m_idx   = 0;
    int          m_phase = 0;   // 0 search, 1 payload, 2 closing
    bit          m_halted = 1'b0;
    logic [95:0] m_id  = '0;
    int          m_cnt = 0;
    bit          e_valid = 1'b0;
    logic [95:0] e_id  = '0;
    int          e_cnt = 0;

    function automatic bit is_mark(int i);
        return hist[i] && hist[i+1] && hist[i+2] && !hist[i+3] && !hist[i+4] && !hist[i+5];
    endfunction

    task automatic model_run();
        forever begin
            if (m_phase == 0) begin
                if (hist.size() < m_idx + 6) break;
                if (is_mark(m_idx)) begin
                    m_idx += 6; m_phase = 1; m_id = '0; m_cnt = 0;
                end else begin
                    m_idx++;
                end
            end else if (m_phase == 1) begin
                if (hist.size() < m_idx + 2) break;
                if (hist[m_idx] != hist[m_idx+1]) begin
                    m_id = {m_id[94:0], hist[m_idx+1]};
                    if (m_cnt < 255) m_cnt++;
                    m_idx += 2;
                end else begin
                    m_phase = 2;
                end
            end else begin
                if (hist.size() < m_idx + 6) break;
                if (is_mark(m_idx)) begin
                    e_valid = 1'b1; e_id = m_id; e_cnt = m_cnt;
                    if (first_only_i) m_halted = 1'b1;
                end
                m_id = '0; m_cnt = 0; m_phase = 0;
                if (m_halted) break;
            end
        end
        while (m_idx > 0) begin
            void'(hist.pop_front());
            m_idx--;
        end
    endtask

    always @(posedge clk_i) begin
        e_valid = 1'b0;
        if (!rst_ni) begin
            hist.delete(); m_idx = 0; m_phase = 0; m_halted = 1'b0;
            m_id = '0; m_cnt = 0; e_id = '0; e_cnt = 0;
        end else if (m_halted) begin
            if (rearm_i) begin
                m_halted = 1'b0; hist.delete(); m_idx = 0; m_phase = 0;
            end
        end else if (in_valid_i) begin
            hist.push_back(in_bit_i);
            model_run();
        end
    end

    // ---------------- per-cycle comparison and report capture ----------------
    int          rep_n = 0;
    logic [95:0] rep_id;
    int          rep_cnt;
    logic [95:0] rep_first;

    always @(negedge clk_i) begin
        if (rst_ni && !done) begin
            chk("R5 id_valid_o", 128'(id_valid_o), 128'(e_valid));
            chk("R3 id words", 128'({id_hi_o, id_mid_o, id_lo_o}), 128'(e_id));
            chk("R9 shift_cnt_o", 128'(shift_cnt_o), 128'(e_cnt[7:0]));
            if (id_valid_o) begin
                if (rep_n == 0) rep_first = {id_hi_o, id_mid_o, id_lo_o};
                rep_n++;
                rep_id  = {id_hi_o, id_mid_o, id_lo_o};
                rep_cnt = int'(shift_cnt_o);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_bit(input bit b);
        if (gap_en) begin
            int g = $urandom_range(0, 2);
            repeat (g) begin
                @(negedge clk_i);
                in_valid_i = 1'b0;
                in_bit_i   = $urandom_range(0, 1);
            end
        end
        @(negedge clk_i);
        in_valid_i = 1'b1;
        in_bit_i   = b;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk_i);
            in_valid_i = 1'b0;
            in_bit_i   = 1'b0;
        end
    endtask

    task automatic send_marker();
        send_bit(1); send_bit(1); send_bit(1);
        send_bit(0); send_bit(0); send_bit(0);
    endtask

    // data bit 1 -> 0,1 ; data bit 0 -> 1,0 ; MSB first
    task automatic send_id44(input logic [43:0] v, input int bad_pair);
        for (int i = 43; i >= 0; i--) begin
            if ((43 - i) == bad_pair) begin
                send_bit(1); send_bit(1);
            end else begin
                send_bit(!v[i]); send_bit(v[i]);
            end
        end
    endtask

    task automatic flush();
        for (int i = 0; i < 8; i++) send_bit(0);
        idle(3);
    endtask

    function automatic logic [95:0] ext44(input logic [43:0] v);
        return {52'd0, v};
    endfunction

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk_i) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        logic [43:0] a, b, c;
        int          r0;
        bit          sat_bits[300];
        logic [95:0] sat_exp;

        idle(4);
        rst_ni = 1'b1;
        idle(2);
        // R1: reset state
        chk("R1 valid after reset", 128'(id_valid_o), 128'(0));
        chk("R1 words after reset", 128'({id_hi_o, id_mid_o, id_lo_o}), 128'(0));
        chk("R1 count after reset", 128'(shift_cnt_o), 128'(0));

        // R3/R5: single frame
        a = {$urandom, $urandom};
        r0 = rep_n;
        send_marker(); send_id44(a, -1); send_marker(); flush();
        chk("R5 one report", 128'(rep_n - r0), 128'(1));
        chk("R3 decoded id", 128'(rep_id), 128'(ext44(a)));
        chk("R3 count 44", 128'(rep_cnt), 128'(44));

        // noise, model-compared only
        for (int i = 0; i < 60; i++) send_bit($urandom_range(0, 1));
        flush();

        // R7/R8: back-to-back frames share a marker
        a = {$urandom, $urandom}; b = {$urandom, $urandom};
        r0 = rep_n; rep_first = '0;
        if (r0 == 0) rep_n = 0;
        send_marker(); send_id44(a, -1); send_marker(); send_id44(b, -1); send_marker(); flush();
        chk("R7 two reports", 128'(rep_n - r0), 128'(2));
        chk("R8 second id clean", 128'(rep_id), 128'(ext44(b)));
        chk("R8 second count", 128'(rep_cnt), 128'(44));

        // R4/R5: corrupted pair drops the frame
        a = {$urandom, $urandom}; c = {$urandom, $urandom};
        r0 = rep_n;
        send_marker(); send_id44(a, 20); send_marker(); flush();
        chk("R4 corrupted frame dropped", 128'(rep_n - r0), 128'(0));
        send_marker(); send_id44(c, -1); send_marker(); flush();
        chk("R5 next good frame", 128'(rep_id), 128'(ext44(c)));

        // R6: rejected close, overlapping marker still found
        a = {$urandom, $urandom}; b = {$urandom, $urandom};
        r0 = rep_n;
        send_marker(); send_id44(a, -1);
        send_bit(0); send_bit(0);
        send_marker(); send_id44(b, -1); send_marker(); flush();
        chk("R6 resume one report", 128'(rep_n - r0), 128'(1));
        chk("R6 resume id", 128'(rep_id), 128'(ext44(b)));

        // R2: marker at an odd offset behind extra 1s
        a = {$urandom, $urandom};
        r0 = rep_n;
        send_bit(1); send_bit(1);
        send_marker(); send_id44(a, -1); send_marker(); flush();
        chk("R2 offset marker", 128'(rep_id), 128'(ext44(a)));
        chk("R2 offset count", 128'(rep_n - r0), 128'(1));

        // R5/R8: empty payload gives zero id and zero count
        r0 = rep_n;
        send_marker(); send_marker(); flush();
        chk("R5 empty payload report", 128'(rep_n - r0), 128'(1));
        chk("R8 empty payload id", 128'(rep_id), 128'(0));
        chk("R8 empty payload count", 128'(rep_cnt), 128'(0));

        // R10: gaps in the valid strobe
        a = {$urandom, $urandom};
        gap_en = 1'b1;
        send_marker(); send_id44(a, -1); send_marker(); flush();
        gap_en = 1'b0;
        chk("R10 gapped frame", 128'(rep_id), 128'(ext44(a)));

        // R9: saturation and last 96 bits kept
        sat_exp = '0;
        for (int i = 0; i < 300; i++) begin
            sat_bits[i] = $urandom_range(0, 1);
            sat_exp = {sat_exp[94:0], sat_bits[i]};
        end
        send_marker();
        for (int i = 0; i < 300; i++) begin
            send_bit(!sat_bits[i]); send_bit(sat_bits[i]);
        end
        send_marker(); flush();
        chk("R9 saturated count", 128'(rep_cnt), 128'(255));
        chk("R9 last 96 bits", 128'(rep_id), 128'(sat_exp));

        // R11: first-only mode
        a = {$urandom, $urandom}; b = {$urandom, $urandom}; c = {$urandom, $urandom};
        first_only_i = 1'b1;
        idle(2);
        r0 = rep_n;
        send_marker(); send_id44(a, -1); send_marker(); send_marker(); send_id44(b, -1); send_marker(); flush();
        chk("R11 stops after first", 128'(rep_n - r0), 128'(1));
        chk("R11 held first id", 128'({id_hi_o, id_mid_o, id_lo_o}), 128'(ext44(a)));
        @(negedge clk_i); in_valid_i = 1'b0; rearm_i = 1'b1;
        @(negedge clk_i); rearm_i = 1'b0;
        send_marker(); send_id44(c, -1); send_marker(); flush();
        chk("R11 report after rearm", 128'(rep_n - r0), 128'(2));
        chk("R11 rearm id", 128'(rep_id), 128'(ext44(c)));
        first_only_i = 1'b0;
        @(negedge clk_i); rearm_i = 1'b1;
        @(negedge clk_i); rearm_i = 1'b0;
        idle(4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule